// File: doc/BRIEF.md
# Interrupt presentation controller

This block is the per-processor end of an interrupt fabric. External interrupt sources offer it an interrupt as a source number and a priority. The block keeps at most one pending interrupt and drives a single interrupt line to its processor. Priorities are 8-bit values where a smaller number is more favoured. A pending interrupt can be displaced by a more favoured one, or by an inter-processor interrupt (IPI) that software requests through its own priority register. When a source from outside loses its slot it receives a reject pulse, so that it can offer the interrupt again later.

Software controls the block through a write port and a read port. The write port sets the current processor priority, sets the IPI request priority, or signals end-of-interrupt. The read port is an accept read. It returns the 32-bit interrupt register and consumes the pending interrupt, which raises the processor priority to that of the consumed interrupt. When the processor priority is relaxed, the block sends a resend request pulse so that the sources can offer again anything they are holding back.

Top module: `intr_presenter`

## Requirements
- R1: The interrupt register is read as {processor priority[31:24], pending source[23:0]}. A source field of 0 means nothing is pending, and `irq_out` is high exactly when the source field is nonzero.
- R2: Reset is synchronous and active low. After reset the processor priority is 0x00, the source field is 0, `irq_out` is low, no pulse is asserted, and both the pending priority and the IPI request priority are 0xff. An accept issued right after reset returns 0xff as the new processor priority.
- R3: A present request is ignored in two cases. The first is when its priority is greater than or equal to the processor priority. The second is when a source is already pending with a priority less than or equal to the offered one. An ignored request changes no state and emits no pulse.
- R4: A present request that is not ignored loads its source number and priority and raises `irq_out`. If the source it displaces came from an external source, a reject pulse carries the old source number.
- R5: In the cycle of `acc_req`, `acc_data` holds the register value. One cycle later the processor priority equals the old pending priority, the source field is 0, the pending priority is 0xff and `irq_out` is low.
- R6: A processor priority write (`wr_sel`=0, value in `wr_data[7:0]`) that lowers the value stores it. If a source is pending with a priority greater than or equal to the new value, that source is cleared, `irq_out` drops, the pending priority becomes 0xff, and an external owner receives a reject pulse.
- R7: A processor priority write that raises the value pulses `resend_req`. If the IPI request priority is below the new value, it also runs the IPI check of R8 with the stored IPI request priority.
- R8: An IPI priority write (`wr_sel`=1, value in `wr_data[7:0]`) stores the value. If the value is below the processor priority, an IPI check runs. The check does nothing if a source is pending with a priority at or below the IPI priority. Otherwise it rejects any externally owned pending source, loads source number 2 with the IPI priority, and raises `irq_out`.
- R9: An IPI that is displaced or cleared never produces a reject pulse.
- R10: An end-of-interrupt write (`wr_sel`=2) copies `wr_data[31:24]` into the processor priority. It pulses `eoi_valid` with `eoi_src` = `wr_data[23:0]` and pulses `resend_req`. It then runs the IPI check if the IPI request priority is below the new processor priority.
- R11: One operation is taken per cycle, in the order accept, then write, then present. The others in that cycle are dropped. A write with `wr_sel`=3 has no effect.
- R12: The reject, end-of-interrupt and resend outputs are registered pulses. Each appears in the cycle after the operation that caused it and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pres_valid | input | 1 | Present request from a source |
| pres_src | input | 24 | Offered source number |
| pres_prio | input | 8 | Offered priority |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 processor priority, 1 IPI priority, 2 end-of-interrupt, 3 none |
| wr_data | input | 32 | Write value |
| acc_req | input | 1 | Accept read strobe |
| acc_data | output | 32 | Interrupt register value |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source being completed |
| resend_req | output | 1 | Request to all sources to offer again |

## Verification
The hardest case to reach is an IPI that displaces an externally owned interrupt as a side effect of another write, rather than through a direct IPI priority write. In that case an end-of-interrupt write lowers the processor priority while an external source is pending at a less favoured priority than an IPI request priority stored earlier. The stimulus first parks the IPI priority at a low value, then lets an external source become pending under a permissive processor priority, and only then issues the end-of-interrupt write. A single operation must then produce end-of-interrupt, resend and reject pulses together. The pending priority cannot be seen at the ports, so the sequence reads it back through accept reads, which copy it into the visible processor priority field.

// File: rtl/ipres_pkg.sv
// Shared definitions for the interrupt presentation controller.
// Assumes 8-bit priorities and a 24-bit source field inside a 32-bit register.
package ipres_pkg;
    typedef enum logic [1:0] {
        WSEL_CPPR = 2'd0,
        WSEL_IPIP = 2'd1,
        WSEL_EOI  = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/ipres_gate.sv
// Admission test for a present request.
// Assumes smaller priority values are more favoured; busy means a source is pending.
module ipres_gate #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic              busy,
    output logic              take
);
    // Accept only if more favoured than the processor and than any pending source.
    always_comb take = (offer_prio < cur_prio) && !(busy && (pend_prio <= offer_prio));
endmodule

// File: rtl/ipres_ipi_eval.sv
// Decides whether an IPI check may take the pending slot.
// Assumes the caller has already verified the IPI priority beats the processor priority.
module ipres_ipi_eval #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic              busy,
    output logic              take
);
    // The IPI loses to any pending source that is at least as favoured.
    always_comb take = !(busy && (pend_prio <= ipi_prio));
endmodule

// File: rtl/intr_presenter.sv
// Per-processor interrupt presenter: holds one pending interrupt, arbitrates
// present requests, IPI requests and software register operations, and emits
// reject, end-of-interrupt and resend pulses towards the sources.
// Assumes one operation per cycle (accept > write > present) and that the
// IPI source number is never used by an external source.
module intr_presenter #(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pres_valid,
    input  logic [SRC_W-1:0]        pres_src,
    input  logic [PRIO_W-1:0]       pres_prio,
    input  logic                    wr_valid,
    input  logic [1:0]              wr_sel,
    input  logic [PRIO_W+SRC_W-1:0] wr_data,
    input  logic                    acc_req,
    output logic [PRIO_W+SRC_W-1:0] acc_data,
    output logic                    irq_out,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_req
);
    import ipres_pkg::*;

    localparam int REG_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_OFF = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
    logic [SRC_W-1:0]  xisr_q;
    logic              own_q, irq_q;
    logic              rej_v_q, eoi_v_q, rs_q;
    logic [SRC_W-1:0]  rej_s_q, eoi_s_q;

    logic [PRIO_W-1:0] cppr_n, pend_n, mfrr_n;
    logic [SRC_W-1:0]  xisr_n;
    logic              own_n, irq_n;
    logic              rej_v_n, eoi_v_n, rs_n;
    logic [SRC_W-1:0]  rej_s_n, eoi_s_n;

    logic              busy, gate_take, ipi_take;
    logic [PRIO_W-1:0] wr_prio, eoi_prio, ipi_prio;
    wsel_e             wsel;

    // Decode the write operands.
    always_comb begin
        wsel     = wsel_e'(wr_sel);
        wr_prio  = wr_data[PRIO_W-1:0];
        eoi_prio = wr_data[REG_W-1:SRC_W];
        busy     = (xisr_q != '0);
        ipi_prio = (wr_valid && wsel == WSEL_IPIP) ? wr_prio : mfrr_q;
    end

    ipres_gate #(.PRIO_W(PRIO_W)) u_gate (
        .cur_prio  (cppr_q),
        .pend_prio (pend_q),
        .offer_prio(pres_prio),
        .busy      (busy),
        .take      (gate_take)
    );

    ipres_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
        .pend_prio(pend_q),
        .ipi_prio (ipi_prio),
        .busy     (busy),
        .take     (ipi_take)
    );

    // Next-state selection for the one operation taken this cycle.
    always_comb begin
        cppr_n = cppr_q; pend_n = pend_q; mfrr_n = mfrr_q;
        xisr_n = xisr_q; own_n = own_q; irq_n = irq_q;
        rej_v_n = 1'b0; rej_s_n = '0;
        eoi_v_n = 1'b0; eoi_s_n = '0;
        rs_n = 1'b0;
        if (acc_req) begin
            cppr_n = pend_q;
            xisr_n = '0;
            pend_n = PRIO_OFF;
            own_n  = 1'b0;
            irq_n  = 1'b0;
        end else if (wr_valid) begin
            case (wsel)
                WSEL_CPPR: begin
                    cppr_n = wr_prio;
                    if (wr_prio < cppr_q) begin
                        if (busy && (wr_prio <= pend_q)) begin
                            xisr_n  = '0;
                            pend_n  = PRIO_OFF;
                            irq_n   = 1'b0;
                            own_n   = 1'b0;
                            rej_v_n = own_q;
                            rej_s_n = own_q ? xisr_q : '0;
                        end
                    end else if (wr_prio > cppr_q) begin
                        rs_n = 1'b1;
                        if ((mfrr_q < wr_prio) && ipi_take) begin
                            rej_v_n = busy && own_q;
                            rej_s_n = (busy && own_q) ? xisr_q : '0;
                            xisr_n  = IPI_NUM;
                            pend_n  = mfrr_q;
                            own_n   = 1'b0;
                            irq_n   = 1'b1;
                        end
                    end
                end
                WSEL_IPIP: begin
                    mfrr_n = wr_prio;
                    if ((wr_prio < cppr_q) && ipi_take) begin
                        rej_v_n = busy && own_q;
                        rej_s_n = (busy && own_q) ? xisr_q : '0;
                        xisr_n  = IPI_NUM;
                        pend_n  = wr_prio;
                        own_n   = 1'b0;
                        irq_n   = 1'b1;
                    end
                end
                WSEL_EOI: begin
                    cppr_n  = eoi_prio;
                    eoi_v_n = 1'b1;
                    eoi_s_n = wr_data[SRC_W-1:0];
                    rs_n    = 1'b1;
                    if ((mfrr_q < eoi_prio) && ipi_take) begin
                        rej_v_n = busy && own_q;
                        rej_s_n = (busy && own_q) ? xisr_q : '0;
                        xisr_n  = IPI_NUM;
                        pend_n  = mfrr_q;
                        own_n   = 1'b0;
                        irq_n   = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (pres_valid && gate_take) begin
            rej_v_n = busy && own_q;
            rej_s_n = (busy && own_q) ? xisr_q : '0;
            xisr_n  = pres_src;
            pend_n  = pres_prio;
            own_n   = 1'b1;
            irq_n   = 1'b1;
        end
    end

    // State and pulse registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cppr_q <= '0; xisr_q <= '0; pend_q <= PRIO_OFF; mfrr_q <= PRIO_OFF;
            own_q <= 1'b0; irq_q <= 1'b0;
            rej_v_q <= 1'b0; rej_s_q <= '0;
            eoi_v_q <= 1'b0; eoi_s_q <= '0; rs_q <= 1'b0;
        end else begin
            cppr_q <= cppr_n; xisr_q <= xisr_n; pend_q <= pend_n; mfrr_q <= mfrr_n;
            own_q <= own_n; irq_q <= irq_n;
            rej_v_q <= rej_v_n; rej_s_q <= rej_s_n;
            eoi_v_q <= eoi_v_n; eoi_s_q <= eoi_s_n; rs_q <= rs_n;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        acc_data   = {cppr_q, xisr_q};
        irq_out    = irq_q;
        rej_valid  = rej_v_q;
        rej_src    = rej_s_q;
        eoi_valid  = eoi_v_q;
        eoi_src    = eoi_s_q;
        resend_req = rs_q;
    end

    // R1
    irq_matches_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (acc_data[SRC_W-1:0] != '0));

    // R9
    no_ipi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != IPI_NUM));

    // R5
    accept_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> (!irq_out && acc_data[SRC_W-1:0] == '0
                     && acc_data[REG_W-1:SRC_W] == $past(pend_q)));

    // R3
    low_offer_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_valid && !acc_req && !wr_valid && pres_prio >= cppr_q)
        |=> ($stable(acc_data) && !rej_valid));

    // R10
    eoi_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !acc_req && wr_sel == 2'd2) |=> (eoi_valid && resend_req));
endmodule

// File: tb/intr_presenter_bench.sv
`timescale 1ns/1ps
module intr_presenter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pres_valid = 1'b0;
    logic [23:0] pres_src = '0;
    logic [7:0]  pres_prio = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        acc_req = 1'b0;
    logic [31:0] acc_data;
    logic        irq_out, rej_valid, eoi_valid, resend_req;
    logic [23:0] rej_src, eoi_src;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    intr_presenter u_intr_presenter (
        .clk(clk), .rst_n(rst_n),
        .pres_valid(pres_valid), .pres_src(pres_src), .pres_prio(pres_prio),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_req(acc_req), .acc_data(acc_data), .irq_out(irq_out),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    // op: 0 present {prio,src}, 1 cppr, 2 ipi prio, 3 eoi, 4 accept, 5 write sel 3
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] dat;
        logic [31:0] e_acc;
        logic        e_irq;
        logic        e_rv;
        logic [23:0] e_rs;
        logic        e_ev;
        logic [23:0] e_es;
        logic        e_rq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 32'h000000ff, 32'hff000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1, 8'd7},  // R7
        '{3'd0, 32'h05000010, 32'hff000010, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd4},  // R4
        '{3'd0, 32'h05000020, 32'hff000010, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd3},  // R3
        '{3'd0, 32'h03000030, 32'hff000030, 1'b1, 1'b1, 24'h10, 1'b0, 24'h0,  1'b0, 8'd4},  // R4
        '{3'd0, 32'hff000040, 32'hff000030, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd3},  // R3
        '{3'd4, 32'h0,        32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd5},  // R5
        '{3'd3, 32'hff000030, 32'hff000000, 1'b0, 1'b0, 24'h0,  1'b1, 24'h30, 1'b1, 8'd10}, // R10
        '{3'd0, 32'h08000050, 32'hff000050, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd4},  // R4
        '{3'd2, 32'h00000008, 32'hff000050, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd8},  // R8
        '{3'd2, 32'h00000004, 32'hff000002, 1'b1, 1'b1, 24'h50, 1'b0, 24'h0,  1'b0, 8'd8},  // R8
        '{3'd0, 32'h01000060, 32'hff000060, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd9},  // R9
        '{3'd1, 32'h00000001, 32'h01000000, 1'b0, 1'b1, 24'h60, 1'b0, 24'h0,  1'b0, 8'd6},  // R6
        '{3'd1, 32'h00000006, 32'h06000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1, 8'd7},  // R7
        '{3'd1, 32'h00000004, 32'h04000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd9},  // R9
        '{3'd4, 32'h0,        32'hff000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd5},  // R5
        '{3'd1, 32'h00000080, 32'h80000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd6},  // R6
        '{3'd0, 32'h80000070, 32'h80000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd3},  // R3
        '{3'd0, 32'h7f000070, 32'h80000070, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd4},  // R4
        '{3'd5, 32'h12345678, 32'h80000070, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 8'd11}, // R11
        '{3'd3, 32'h05000000, 32'h05000002, 1'b1, 1'b1, 24'h70, 1'b1, 24'h0,  1'b1, 8'd10}  // R10
    };

    task automatic check(input string tag, input logic [83:0] act, input logic [83:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [83:0] observe();
        return {acc_data, irq_out, rej_valid, rej_src, eoi_valid, eoi_src, resend_req};
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [31:0] dat);
        @(negedge clk);
        case (op)
            3'd0: begin pres_valid = 1'b1; pres_prio = dat[31:24]; pres_src = dat[23:0]; end
            3'd1: begin wr_valid = 1'b1; wr_sel = 2'd0; wr_data = dat; end
            3'd2: begin wr_valid = 1'b1; wr_sel = 2'd1; wr_data = dat; end
            3'd3: begin wr_valid = 1'b1; wr_sel = 2'd2; wr_data = dat; end
            3'd4: acc_req = 1'b1;
            default: begin wr_valid = 1'b1; wr_sel = 2'd3; wr_data = dat; end
        endcase
        @(posedge clk);
        #1;
        pres_valid = 1'b0; wr_valid = 1'b0; acc_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2: reset state seen at the ports
        check("R2 reset outputs", observe(), 84'h0);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].dat);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), observe(),
                  {VECS[i].e_acc, VECS[i].e_irq, VECS[i].e_rv, VECS[i].e_rs,
                   VECS[i].e_ev, VECS[i].e_es, VECS[i].e_rq});
        end

        // R12: pulses from the last vector last one cycle
        @(negedge clk);
        check("R12 pulses drop", observe(), {32'h05000002, 1'b1, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0});

        // R11 and R5: accept with a concurrent present; returned value before the edge
        @(negedge clk);
        acc_req = 1'b1; pres_valid = 1'b1; pres_prio = 8'h00; pres_src = 24'h99;
        #1;
        check("R5 accept return", {acc_data, 52'h0}, {32'h05000002, 52'h0});
        @(posedge clk);
        #1 acc_req = 1'b0; pres_valid = 1'b0;
        @(negedge clk);
        check("R11 present dropped under accept", observe(),
              {32'h04000000, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0});

        // R2: pending priority is 0xff after reset
        do_reset();
        do_op(3'd4, 32'h0);
        check("R2 pending priority after reset", observe(),
              {32'hff000000, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0, 1'b0});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule